// File: doc/BRIEF.md
# Two-Channel Serial Audio Frame Engine

This block moves stereo PCM samples between a small word FIFO and a serial audio data line. In transmit mode it shifts samples out on `sdo`; in receive mode it shifts them in from `sdi`. It never generates the bit clock or the frame clock. It follows `bclk` and `lrclk` from an external clock generator and samples both, together with `sdi`, on the system clock. The bit clock must therefore be several times slower than `clk`.

Framing is set by static control inputs:
- I2S framing, where data starts one bit slot after the frame edge, or left-justified framing, where data starts on the frame edge.
- A choice of which bit-clock edge launches and which samples.
- Frame-clock polarity.
- Sample width of 16, 20 or 24 bits.

Host traffic uses a 32-bit word interface: a push strobe in transmit mode and a pop strobe in receive mode. Sixteen-bit stereo frames fit in one word. Wider samples take one word per channel.

After `run` is raised, the engine stays silent until the host makes its first data access. The transfer then begins at the next left-channel half. Starvation in transmit and a full FIFO in receive raise sticky flags. Lowering `run` clears both flags and empties the FIFO.

Top module: `stereo_serial_engine`

## Requirements
- R1: After reset the outputs are as follows: `sdo` is 0, both flags are 0 and `rd_data` is 0.
- R2: With `i2s_mode` = 0 (left-justified), the sample MSB is driven in the first bit slot of a channel half. The slot begins at the launch edge where `lrclk` changes. The remaining bits follow MSB first, and every slot after the last sample bit carries 0.
- R3: With `i2s_mode` = 1, each channel's MSB is driven one slot after the frame edge. The slot at the frame edge carries 0.
- R4: The left channel is the half in which `lrclk` is low when `lr_invert` = 0, and the half in which it is high when `lr_invert` = 1.
- R5: With `bclk_invert` = 0, data is launched on the falling edge of `bclk` and captured on the rising edge. With `bclk_invert` = 1 the two edges swap.
- R6: `width_code` 0 selects 16-bit samples, 4 selects 20-bit and 8 selects 24-bit. Any other code acts as 16-bit.
- R7: In transmit with 16-bit samples, one FIFO word holds a whole frame: left in bits [31:16] and right in bits [15:0]. With 20- or 24-bit samples, each word holds one channel in bits [W-1:0], left word first.
- R8: In receive, captured samples go into the FIFO in the R7 layout with unused upper bits 0. `rd_data` shows the head word and `rd_en` pops it. `rd_data` is 0 when the FIFO is empty. `sdo` stays 0 in receive mode.
- R9: After `run` rises, nothing is sent or captured until the first `wr_en` (transmit) or `rd_en` (receive). The transfer then starts at the next left-half frame edge.
- R10: In transmit, a word needed while the FIFO is empty sets `underflow`, which stays set while `run` is high. The missing channel halves are sent as zeros.
- R11: In receive, a word completed while the 4-word FIFO is full sets `overflow`, which stays set while `run` is high. That word is dropped and the stored words are kept.
- R12: While `run` is 0, the FIFO is emptied, both flags read 0, `sdo` is 0 and the engine waits for a new first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Engine enable; low flushes and idles |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| i2s_mode | input | 1 | 1 = one-slot data delay (I2S), 0 = left-justified |
| bclk_invert | input | 1 | Swaps launch and capture edges of `bclk` |
| lr_invert | input | 1 | Left channel while `lrclk` is high |
| width_code | input | 4 | Sample width code (0, 4, 8) |
| bclk | input | 1 | Bit clock from the clock generator |
| lrclk | input | 1 | Frame clock from the clock generator |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| wr_en | input | 1 | Push `wr_data` into the FIFO (transmit) |
| wr_data | input | 32 | Word to push |
| rd_en | input | 1 | Pop the head word (receive) |
| rd_data | output | 32 | Head word in receive mode, else 0 |
| underflow | output | 1 | Sticky transmit starvation flag |
| overflow | output | 1 | Sticky receive FIFO-full flag |

## Verification
A wrong slot count or channel state shows on `sdo` within one bit slot of the next frame edge. It appears as a sample shifted by one position, or as left and right swapped. A FIFO pointer or packing error appears on the first word after the start: as a wrong half, a wrong word on `rd_data`, or a flag that rises one frame early or late. Every format combination is therefore checked per channel half across consecutive frames, including the frame in which the FIFO runs dry or fills up.

// File: rtl/sse_pkg.sv
// Shared constants and width-code decoding for the serial audio engine.
// Assumes 32-bit host words and samples of at most 24 bits.
package sse_pkg;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = WORD_W / 2;
    localparam int SAMPLE_MAX = 24;
    localparam int WL_W       = $clog2(SAMPLE_MAX + 1);
    localparam int CODE_W     = 4;

    // Sample width in bits for a width code; reserved codes fall back to 16.
    function automatic logic [WL_W-1:0] code_to_width(input logic [CODE_W-1:0] code);
        case (code)
            4'd4:    return WL_W'(20);
            4'd8:    return WL_W'(24);
            default: return WL_W'(16);
        endcase
    endfunction

    // True when one FIFO word carries a single channel.
    function automatic logic code_is_wide(input logic [CODE_W-1:0] code);
        return (code == 4'd4) || (code == 4'd8);
    endfunction
endpackage

// File: rtl/sse_clk_track.sv
// Samples bclk, lrclk and sdi on the system clock and turns them into
// launch/capture strobes plus a per-half slot counter and channel bit.
// Assumes bclk is at least 4x slower than clk and lrclk changes on launch edges.
module sse_clk_track #(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              lrclk,
    input  logic              sdi,
    input  logic              bclk_invert,
    input  logic              lr_invert,
    output logic              launch,
    output logic              capture,
    output logic              new_half,
    output logic              chan,
    output logic [SLOT_W-1:0] slot,
    output logic              sdi_s
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = {SLOT_W{1'b1}};

    logic              bclk_s, bclk_d, lr_s, lr_prev, chan_q;
    logic [SLOT_W-1:0] slot_q, slot_nx;
    logic              rise, fall;

    // Register the external pins once and keep the previous bclk level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_s <= 1'b0;
            bclk_d <= 1'b0;
            lr_s   <= 1'b0;
            sdi_s  <= 1'b0;
        end else begin
            bclk_s <= bclk;
            bclk_d <= bclk_s;
            lr_s   <= lrclk;
            sdi_s  <= sdi;
        end
    end

    // Edge selection and slot arithmetic for the current cycle.
    always_comb begin
        rise     = bclk_s & ~bclk_d;
        fall     = ~bclk_s & bclk_d;
        launch   = bclk_invert ? rise : fall;
        capture  = bclk_invert ? fall : rise;
        new_half = launch & (lr_s != lr_prev);
        if (new_half)
            slot_nx = '0;
        else if (slot_q == SLOT_LAST)
            slot_nx = slot_q;
        else
            slot_nx = slot_q + 1'b1;
        slot = launch ? slot_nx : slot_q;
        chan = launch ? (lr_s ^ lr_invert) : chan_q;
    end

    // Hold slot, channel and frame-clock history between launch edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev <= 1'b0;
            slot_q  <= '0;
            chan_q  <= 1'b0;
        end else if (launch) begin
            lr_prev <= lr_s;
            slot_q  <= slot_nx;
            chan_q  <= lr_s ^ lr_invert;
        end
    end
endmodule

// File: rtl/sse_fifo.sv
// Small synchronous word FIFO with flush. Pushes to a full FIFO and pops
// from an empty one are ignored; head is valid whenever empty is low.
module sse_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    // Qualify requests against the occupancy.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        head    = mem[rd_ptr];
    end

    // Storage array, written without reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/sse_tx.sv
// Transmit serializer: fetches words at channel-half starts, selects the
// channel sample and drives one bit per launch edge, MSB first.
// Assumes go is high only while the transfer is active.
module sse_tx
    import sse_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              go,
    input  logic              launch,
    input  logic              new_half,
    input  logic              chan,
    input  logic [SLOT_W-1:0] slot,
    input  logic              delay,
    input  logic [WL_W-1:0]   width,
    input  logic              wide,
    input  logic [WORD_W-1:0] fifo_head,
    input  logic              fifo_empty,
    output logic              pop,
    output logic              starve,
    output logic              sdo
);
    logic [SAMPLE_MAX-1:0] cur_q, smp;
    logic [HALF_W-1:0]     right_q;
    logic [WORD_W-1:0]     word;
    logic [SLOT_W:0]       k;
    logic                  in_word, need;
    logic [WL_W-1:0]       idx;

    // Word fetch, sample selection and bit-index computation.
    always_comb begin
        need   = go & launch & new_half & (wide | ~chan);
        pop    = need & ~fifo_empty;
        starve = need & fifo_empty;
        word   = fifo_empty ? '0 : fifo_head;
        if (launch && new_half) begin
            if (wide)       smp = word[SAMPLE_MAX-1:0];
            else if (!chan) smp = SAMPLE_MAX'(word[WORD_W-1:HALF_W]);
            else            smp = SAMPLE_MAX'(right_q);
        end else begin
            smp = cur_q;
        end
        k       = {1'b0, slot} - (SLOT_W+1)'(delay);
        in_word = ~k[SLOT_W] && (k < (SLOT_W+1)'(width));
        idx     = width - WL_W'(1) - k[WL_W-1:0];
    end

    // Launch-edge register for the data pin and the held samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            sdo     <= 1'b0;
            cur_q   <= '0;
            right_q <= '0;
        end else if (launch) begin
            sdo   <= go & in_word & smp[idx];
            cur_q <= smp;
            if (need && !wide) right_q <= word[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/sse_rx.sv
// Receive deserializer: shifts sdi in on capture edges inside the sample
// window and emits a FIFO word when a frame (16-bit) or a channel (wide) ends.
module sse_rx
    import sse_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              active,
    input  logic              capture,
    input  logic              chan,
    input  logic [SLOT_W-1:0] slot,
    input  logic              delay,
    input  logic [WL_W-1:0]   width,
    input  logic              wide,
    input  logic              sdi,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);
    logic [SAMPLE_MAX-2:0] shreg;
    logic [SAMPLE_MAX-1:0] mask, got;
    logic [HALF_W-1:0]     left_q;
    logic [SLOT_W:0]       k;
    logic                  in_word, take, done;

    // Window test, width mask and word assembly.
    always_comb begin
        k       = {1'b0, slot} - (SLOT_W+1)'(delay);
        in_word = ~k[SLOT_W] && (k < (SLOT_W+1)'(width));
        take    = enable & active & capture & in_word;
        done    = take && (k == (SLOT_W+1)'(width) - 1'b1);
        for (int i = 0; i < SAMPLE_MAX; i++) mask[i] = (i < int'(width));
        got       = {shreg, sdi} & mask;
        push      = done & (wide | chan);
        push_data = wide ? WORD_W'(got) : {left_q, got[HALF_W-1:0]};
    end

    // Shift register and held left sample for 16-bit packing.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            shreg  <= '0;
            left_q <= '0;
        end else begin
            if (take) shreg <= {shreg[SAMPLE_MAX-3:0], sdi};
            if (done && !wide && !chan) left_q <= got[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/stereo_serial_engine.sv
// Top of the two-channel serial audio engine: clock tracking, word FIFO,
// serializer and deserializer, plus start gating and sticky error flags.
// Assumes control inputs are changed only while run is low.
module stereo_serial_engine
    import sse_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int SLOT_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rx_mode,
    input  logic              i2s_mode,
    input  logic              bclk_invert,
    input  logic              lr_invert,
    input  logic [CODE_W-1:0] width_code,
    input  logic              bclk,
    input  logic              lrclk,
    input  logic              sdi,
    output logic              sdo,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              underflow,
    output logic              overflow
);
    logic              launch, capture, new_half, chan, sdi_s;
    logic [SLOT_W-1:0] slot;
    logic [WL_W-1:0]   width;
    logic              wide, armed_q, active_q, go, frame_start, access;
    logic              f_push, f_pop, f_empty, f_full;
    logic [WORD_W-1:0] f_in, f_head;
    logic              tx_pop, tx_starve, rx_push;
    logic [WORD_W-1:0] rx_word;

    sse_clk_track #(.SLOT_W(SLOT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdi(sdi),
        .bclk_invert(bclk_invert), .lr_invert(lr_invert),
        .launch(launch), .capture(capture), .new_half(new_half),
        .chan(chan), .slot(slot), .sdi_s(sdi_s)
    );

    // Decode format, start condition and FIFO steering.
    always_comb begin
        width       = code_to_width(width_code);
        wide        = code_is_wide(width_code);
        frame_start = launch & new_half & ~chan;
        go          = active_q | (armed_q & frame_start);
        access      = rx_mode ? rd_en : wr_en;
        f_push      = rx_mode ? rx_push : wr_en;
        f_in        = rx_mode ? rx_word : wr_data;
        f_pop       = rx_mode ? rd_en : tx_pop;
        rd_data     = (rx_mode && !f_empty) ? f_head : '0;
    end

    sse_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(~run),
        .push(f_push), .push_data(f_in), .pop(f_pop),
        .head(f_head), .empty(f_empty), .full(f_full)
    );

    sse_tx #(.SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(run & ~rx_mode), .go(go),
        .launch(launch), .new_half(new_half), .chan(chan), .slot(slot),
        .delay(i2s_mode), .width(width), .wide(wide),
        .fifo_head(f_head), .fifo_empty(f_empty),
        .pop(tx_pop), .starve(tx_starve), .sdo(sdo)
    );

    sse_rx #(.SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(run & rx_mode), .active(active_q),
        .capture(capture), .chan(chan), .slot(slot),
        .delay(i2s_mode), .width(width), .wide(wide), .sdi(sdi_s),
        .push(rx_push), .push_data(rx_word)
    );

    // Start gating on first access, and sticky starvation/full flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            armed_q   <= 1'b0;
            active_q  <= 1'b0;
            underflow <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            if (access)                 armed_q   <= 1'b1;
            if (armed_q && frame_start) active_q  <= 1'b1;
            if (tx_starve && !rx_mode)  underflow <= 1'b1;
            if (rx_push && f_full)      overflow  <= 1'b1;
        end
    end
endmodule

// File: rtl/sse_checker.sv
// Temporal checks on the engine's ports, attached to every instance by bind.
module sse_checker (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic rx_mode,
    input logic sdo,
    input logic underflow,
    input logic overflow
);
    // R12
    idle_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sdo);
    // R12
    idle_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!underflow && !overflow));
    // R8
    rx_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mode |=> !sdo);
    // R10
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && run) |=> underflow);
    // R10
    underflow_tx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> !rx_mode);
    // R11
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && run) |=> overflow);
    // R11
    overflow_rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> rx_mode);
endmodule

bind stereo_serial_engine sse_checker i_sse_checker (
    .clk(clk), .rst_n(rst_n), .run(run), .rx_mode(rx_mode), .sdo(sdo),
    .underflow(underflow), .overflow(overflow)
);

// File: tb/test_stereo_serial_engine.sv
`timescale 1ns/1ps
module test_stereo_serial_engine;
    logic        clk = 1'b0;
    logic        rst_n, run, rx_mode, i2s_mode, bclk_invert, lr_invert;
    logic [3:0]  width_code;
    logic        bclk, lrclk, sdi, sdo, wr_en, rd_en, underflow, overflow;
    logic [31:0] wr_data, rd_data;

    int          n_chk = 0, n_err = 0;
    logic [31:0] pend [4];
    int          npush = 0;

    // Stimulus table: {rx, i2s, bclk_inv, lr_inv, width_code}
    localparam logic [7:0] VEC [9] = '{
        8'b0_0_0_0_0000, 8'b0_1_0_0_0000, 8'b0_1_1_0_1000,
        8'b0_0_0_1_0100, 8'b0_1_1_1_0100, 8'b1_1_0_0_0000,
        8'b1_0_0_1_1000, 8'b1_1_1_0_0100, 8'b1_0_1_1_0000
    };

    always #2.5 clk = ~clk;

    stereo_serial_engine i_stereo_serial_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .rx_mode(rx_mode),
        .i2s_mode(i2s_mode), .bclk_invert(bclk_invert), .lr_invert(lr_invert),
        .width_code(width_code), .bclk(bclk), .lrclk(lrclk), .sdi(sdi),
        .sdo(sdo), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .underflow(underflow), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int wid(input logic [3:0] c);
        return (c == 4'd4) ? 20 : (c == 4'd8) ? 24 : 16;
    endfunction

    function automatic logic [23:0] mk(input int seed, input int f, input int c, input int w);
        logic [31:0] x;
        x = 32'(seed) * 32'h9E3779B1 ^ 32'(f) * 32'h85EBCA6B ^ 32'(c) * 32'hC2B2AE35;
        x = x ^ (x >> 15) ^ (x << 7);
        return x[23:0] & ((24'h1 << w) - 24'h1);
    endfunction

    // Expected slot pattern of one channel half (bit s = slot s).
    function automatic logic [31:0] half_pat(input logic [23:0] smp, input int w, input int dly);
        logic [31:0] r;
        for (int s = 0; s < 32; s++) begin
            int k = s - dly;
            r[s] = (k >= 0 && k < w) ? smp[w-1-k] : 1'b0;
        end
        return r;
    endfunction

    // One 64-slot frame as clock generator and codec; 16 clk per slot.
    task automatic frame(input logic [63:0] drive, output logic [63:0] cap, input bit arm);
        for (int b = 0; b < 64; b++) begin
            for (int p = 0; p < 16; p++) begin
                @(negedge clk);
                wr_en = arm && b == 40 && p < npush && !rx_mode;
                wr_data = (p < 4) ? pend[p] : 32'h0;
                rd_en = arm && b == 40 && p == 0 && rx_mode;
                if (p == 0) begin
                    bclk  = bclk_invert;
                    lrclk = (b >= 32) ^ lr_invert;
                    sdi   = drive[b];
                end
                if (p == 7) cap[b] = sdo;
                if (p == 8) bclk = ~bclk_invert;
            end
        end
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic read_word(output logic [31:0] v);
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic setup(input logic [7:0] v);
        run = 1'b0;
        repeat (3) @(negedge clk);
        {rx_mode, i2s_mode, bclk_invert, lr_invert, width_code} = v;
        @(negedge clk);
        run = 1'b1;
    endtask

    task automatic scen(input logic [7:0] v, input int seed);
        logic [63:0] cap, drv;
        logic [31:0] pl, pr, got, exp;
        logic [23:0] l [2];
        logic [23:0] r [2];
        int          w, dly;
        bit          wide;
        string       tag;
        setup(v);
        w = wid(width_code);
        dly = int'(i2s_mode);
        wide = (w != 16);
        tag = $sformatf("%s%s%s%s %s", i2s_mode ? "R3" : "R2", lr_invert ? " R4" : "",
                        bclk_invert ? " R5" : "", wide ? " R6" : "", rx_mode ? "R8" : "R7");
        for (int f = 0; f < 2; f++) begin
            l[f] = mk(seed, f, 0, w);
            r[f] = mk(seed, f, 1, w);
        end
        if (!rx_mode) begin
            if (wide) begin
                pend[0] = 32'(l[0]); pend[1] = 32'(r[0]);
                pend[2] = 32'(l[1]); pend[3] = 32'(r[1]);
                npush = 4;
            end else begin
                pend[0] = {l[0][15:0], r[0][15:0]};
                pend[1] = {l[1][15:0], r[1][15:0]};
                npush = 2;
            end
            frame(64'h0, cap, 1'b1);
            for (int f = 0; f < 2; f++) begin
                frame(64'h0, cap, 1'b0);
                pl = half_pat(l[f], w, dly);
                pr = half_pat(r[f], w, dly);
                chk(cap[31:0] == pl, {tag, " left half"}, cap[31:0], pl);
                chk(cap[63:32] == pr, {tag, " right half"}, cap[63:32], pr);
            end
            chk(underflow == 1'b0, "R10 no flag while fed", 32'(underflow), 0);
            frame(64'h0, cap, 1'b0);
            chk(cap == 64'h0, "R10 zeros when starved", cap[31:0] | cap[63:32], 0);
            chk(underflow == 1'b1, "R10 flag when starved", 32'(underflow), 1);
        end else begin
            frame(64'h0, cap, 1'b1);
            for (int f = 0; f < 2; f++) begin
                drv = {half_pat(r[f], w, dly), half_pat(l[f], w, dly)};
                frame(drv, cap, 1'b0);
            end
            for (int i = 0; i < (wide ? 4 : 2); i++) begin
                read_word(got);
                if (wide) exp = 32'((i % 2 == 0) ? l[i/2] : r[i/2]);
                else      exp = {l[i][15:0], r[i][15:0]};
                chk(got == exp, {tag, " received word"}, got, exp);
            end
            chk(overflow == 1'b0, "R11 no flag when drained", 32'(overflow), 0);
        end
    endtask

    initial begin
        #950000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [63:0] cap, drv;
        logic [31:0] got;
        logic [23:0] l, r;
        rst_n = 1'b0; run = 1'b0; rx_mode = 1'b0; i2s_mode = 1'b0;
        bclk_invert = 1'b0; lr_invert = 1'b0; width_code = 4'd0;
        bclk = 1'b1; lrclk = 1'b1; sdi = 1'b0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        for (int i = 0; i < 4; i++) pend[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sdo == 1'b0, "R1 sdo", 32'(sdo), 0);
        chk(underflow == 1'b0 && overflow == 1'b0, "R1 flags", {30'b0, underflow, overflow}, 0);
        chk(rd_data == 32'h0, "R1 rd_data", rd_data, 0);

        for (int i = 0; i < 9; i++) scen(VEC[i], i + 1);

        // R9: running without an access sends nothing and fetches nothing
        setup(8'b0_0_0_0_0000);
        frame(64'h0, cap, 1'b0);
        frame(64'h0, cap, 1'b0);
        chk(cap == 64'h0, "R9 silent before access", cap[31:0] | cap[63:32], 0);
        chk(underflow == 1'b0, "R9 no fetch before access", 32'(underflow), 0);

        // R11: five 16-bit frames into a 4-word FIFO
        setup(8'b1_0_0_0_0000);
        frame(64'h0, cap, 1'b1);
        for (int f = 0; f < 5; f++) begin
            l = mk(77, f, 0, 16);
            r = mk(77, f, 1, 16);
            drv = {half_pat(r, 16, 0), half_pat(l, 16, 0)};
            frame(drv, cap, 1'b0);
        end
        chk(overflow == 1'b1, "R11 flag on full", 32'(overflow), 1);
        for (int f = 0; f < 4; f++) begin
            read_word(got);
            l = mk(77, f, 0, 16);
            r = mk(77, f, 1, 16);
            chk(got == {l[15:0], r[15:0]}, "R11 stored words kept", got, {l[15:0], r[15:0]});
        end
        read_word(got);
        chk(got == 32'h0, "R11 extra word dropped", got, 0);
        chk(overflow == 1'b1, "R11 flag sticky", 32'(overflow), 1);

        // R12: one more word captured, then run low flushes and clears
        l = mk(88, 0, 0, 16);
        r = mk(88, 0, 1, 16);
        frame({half_pat(r, 16, 0), half_pat(l, 16, 0)}, cap, 1'b0);
        run = 1'b0;
        repeat (2) @(negedge clk);
        chk(overflow == 1'b0, "R12 flag cleared", 32'(overflow), 0);
        chk(sdo == 1'b0, "R12 sdo low", 32'(sdo), 0);
        run = 1'b1;
        repeat (2) @(negedge clk);
        chk(rd_data == 32'h0, "R12 FIFO flushed", rd_data, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule